// File: doc/BRIEF.md
# Isochronous Transmit Interrupt Event and Mask Bank

This block collects interrupt requests from eight isochronous transmit contexts. Each event bit is latched on the rising edge of its context's request line. A plain single-cycle 32-bit register bus gives access to the bank. The event bits and the enable (mask) bits each have two word addresses: one where writing a 1 sets a bit, and one where writing a 1 clears it. A write of 0 to any bit leaves that bit unchanged.

A single summary interrupt output is high while any latched event has its enable bit set. Software reads the masked view of the events to find the contexts that are pending. It then clears the events it has handled by writing 1s to the event clear address. The request lines are assumed to be synchronous to `clk`. The bus address is a byte address, and the default base is 0x90.

Top module: `isotx_irq_bank`

## Requirements
- R1: After reset, all event bits and all mask bits are 0, `irq_out` is 0, and all four bank addresses read as zero.
- R2: A rising edge on `req_irq[n]` (low in one cycle, high in the next) sets event bit n at that clock edge. Several lines rising together set all of their bits.
- R3: A request line that stays high does not set its event bit again after the bit is cleared. A line that is already high when reset is released sets nothing.
- R4: A write to the event set address (base+0x0) sets every event bit n for which `bus_wdata[n]` is 1. Bits written as 0 keep their value.
- R5: A write to the event clear address (base+0x4) clears every event bit n for which `bus_wdata[n]` is 1. Bits written as 0 keep their value. No other action clears an event bit except reset.
- R6: A read of base+0x0 returns the raw event bits in bits 7:0. A read of base+0x4 returns the event bits ANDed with the mask bits.
- R7: A write to base+0x8 sets the mask bits written as 1, and a write to base+0xC clears them. A read of either address returns the mask bits. Mask bit n enables event bit n.
- R8: `irq_out` is 1 exactly when some event bit and its mask bit are both 1. It changes in the cycle after the write or edge that causes the change.
- R9: If a rising edge and a clear write hit the same event bit in the same cycle, the bit ends up set.
- R10: Read data bits 31:8 are always zero. Write data bits 31:8 are ignored. Any other address reads as zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released internally in step with `clk` |
| req_irq | input | 8 | Per-context interrupt request lines; a rising edge latches the event |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe; the write takes effect at the next rising edge of `clk` |
| bus_wdata | input | 32 | Write data, one bit per context in bits 7:0 |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| irq_out | output | 1 | Summary interrupt: any event that is enabled |

## Verification
The bench builds the bank with its default parameters: eight contexts, a 32-bit data path, an 8-bit byte address and a base of 0x90. With these values both edge contexts (bit 0 and bit 7) can be exercised. The reserved upper half of the data word can be written with ones to show that it is ignored. A neighbouring address just past the bank, and a misaligned address inside it, can also be probed. The edge-detect history is tested by holding a line high across a reset release, and by holding it high across a clear write.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Register selected by the current bus address
  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_EV_SET = 3'd1,
    SEL_EV_CLR = 3'd2,
    SEL_MK_SET = 3'd3,
    SEL_MK_CLR = 3'd4
  } reg_sel_e;

  // Byte offsets of the four words relative to the bank base
  localparam int OFF_EV_SET = 0;
  localparam int OFF_EV_CLR = 4;
  localparam int OFF_MK_SET = 8;
  localparam int OFF_MK_CLR = 12;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] hist_q;
  logic [WIDTH-1:0] hist_d;
  logic             primed_q;

  // History is only trusted after one sample taken out of reset
  always_comb begin
    hist_d = req_i;
    rise_o = req_i & ~hist_q & {WIDTH{primed_q}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      hist_q   <= hist_d;
      primed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_w1sc_reg.sv
module irq_w1sc_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_d;
  logic             en;

  // Set is applied after clear, so a set on the same bit wins
  always_comb begin
    q_d = (q_q & ~clr_i) | set_i;
    en  = (|set_i) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_bank_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h90
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel_o
);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off   = bus_addr - BASE_ADDR;
    sel_o = SEL_NONE;
    case (off)
      ADDR_W'(OFF_EV_SET): sel_o = SEL_EV_SET;
      ADDR_W'(OFF_EV_CLR): sel_o = SEL_EV_CLR;
      ADDR_W'(OFF_MK_SET): sel_o = SEL_MK_SET;
      ADDR_W'(OFF_MK_CLR): sel_o = SEL_MK_CLR;
      default:             sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/isotx_irq_bank.sv
module isotx_irq_bank
  import irq_bank_pkg::*;
#(
  parameter int                NUM_CTX     = 8,
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h90,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTX-1:0] req_irq,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);

  logic               rst_sync_n;
  logic [NUM_CTX-1:0] rise;
  logic [NUM_CTX-1:0] wbits;
  logic [NUM_CTX-1:0] ev_set;
  logic [NUM_CTX-1:0] ev_clr;
  logic [NUM_CTX-1:0] mk_set;
  logic [NUM_CTX-1:0] mk_clr;
  logic [NUM_CTX-1:0] ev_q;
  logic [NUM_CTX-1:0] mk_q;
  logic [NUM_CTX-1:0] rd_bits;
  logic               unused_wdata_hi;
  reg_sel_e           sel;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_rise_detect #(.WIDTH(NUM_CTX)) u_rise (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .req_i  (req_irq),
    .rise_o (rise)
  );

  irq_bus_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .sel_o    (sel)
  );

  // Per-word write strobes; reserved upper write bits are dropped
  always_comb begin
    wbits  = bus_wdata[NUM_CTX-1:0];
    ev_set = (bus_wr && sel == SEL_EV_SET) ? wbits : '0;
    ev_clr = (bus_wr && sel == SEL_EV_CLR) ? wbits : '0;
    mk_set = (bus_wr && sel == SEL_MK_SET) ? wbits : '0;
    mk_clr = (bus_wr && sel == SEL_MK_CLR) ? wbits : '0;
  end

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_CTX];

  irq_w1sc_reg #(.WIDTH(NUM_CTX)) u_ev (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (ev_set | rise),
    .clr_i (ev_clr),
    .q_o   (ev_q)
  );

  irq_w1sc_reg #(.WIDTH(NUM_CTX)) u_mk (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (mk_set),
    .clr_i (mk_clr),
    .q_o   (mk_q)
  );

  always_comb begin
    case (sel)
      SEL_EV_SET:             rd_bits = ev_q;
      SEL_EV_CLR:             rd_bits = ev_q & mk_q;
      SEL_MK_SET, SEL_MK_CLR: rd_bits = mk_q;
      default:                rd_bits = '0;
    endcase
    bus_rdata                = '0;
    bus_rdata[NUM_CTX-1:0]   = rd_bits;
  end

  assign irq_out = |(ev_q & mk_q);

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int                NUM_CTX   = 8,
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h90
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NUM_CTX-1:0] req_irq,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_out,
  input logic [NUM_CTX-1:0] ev_q,
  input logic [NUM_CTX-1:0] mk_q
);

  localparam logic [ADDR_W-1:0] A_EV_SET = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_EV_CLR = BASE_ADDR + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MK_SET = BASE_ADDR + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_MK_CLR = BASE_ADDR + ADDR_W'(12);

  logic [NUM_CTX-1:0] req_prev;
  logic               primed;
  logic [NUM_CTX-1:0] rise_v;
  logic [NUM_CTX-1:0] wlo;
  logic               unused_chk_hi;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_prev <= '0;
      primed   <= 1'b0;
    end else begin
      req_prev <= req_irq;
      primed   <= 1'b1;
    end
  end

  assign rise_v        = req_irq & ~req_prev & {NUM_CTX{primed}};
  assign wlo           = bus_wdata[NUM_CTX-1:0];
  assign unused_chk_hi = ^bus_wdata[DATA_W-1:NUM_CTX];

  // R2
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((ev_q & $past(rise_v)) == $past(rise_v)));

  // R4
  ev_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == A_EV_SET) |=> ((ev_q & $past(wlo)) == $past(wlo)));

  // R5
  ev_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == A_EV_CLR) |=> ((ev_q & $past(wlo & ~rise_v)) == '0));

  // R5
  ev_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|($past(ev_q) & ~ev_q)) |-> $past(bus_wr && bus_addr == A_EV_CLR));

  // R7
  mk_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == A_MK_SET) |=> ((mk_q & $past(wlo)) == $past(wlo)));

  // R7
  mk_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == A_MK_CLR) |=> ((mk_q & $past(wlo)) == '0));

  // R8
  summary_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == A_EV_CLR) |-> (irq_out == (|bus_rdata)));

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == A_EV_CLR && |(wlo & rise_v)) |=>
      ((ev_q & $past(wlo & rise_v)) == $past(wlo & rise_v)));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[DATA_W-1:NUM_CTX] == '0);

endmodule

bind isotx_irq_bank irq_bank_chk #(
  .NUM_CTX   (NUM_CTX),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .req_irq    (req_irq),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_out    (irq_out),
  .ev_q       (ev_q),
  .mk_q       (mk_q)
);

// File: tb/tb_isotx_irq_bank.sv
`timescale 1ns/1ps
module tb_isotx_irq_bank;

  logic        clk;
  logic        rst_n;
  logic [7:0]  req_irq;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int total;
  int bad;

  isotx_irq_bank dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_irq   (req_irq),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0]  addr;
    logic        wr;
    logic [31:0] wdata;
    logic [7:0]  req;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{8'h90, 1'b0, 32'h0,         8'h00, 32'h00, 1'b0, 4'd1},  // R1
    '{8'h98, 1'b0, 32'h0,         8'h00, 32'h00, 1'b0, 4'd1},  // R1
    '{8'h90, 1'b1, 32'hFFFF_0005, 8'h00, 32'h05, 1'b0, 4'd4},  // R4
    '{8'h90, 1'b1, 32'h0,         8'h00, 32'h05, 1'b0, 4'd4},  // R4
    '{8'h98, 1'b1, 32'h0000_0004, 8'h00, 32'h04, 1'b1, 4'd7},  // R7
    '{8'h98, 1'b1, 32'hFFFF_FF00, 8'h00, 32'h04, 1'b1, 4'd10}, // R10
    '{8'h94, 1'b0, 32'h0,         8'h00, 32'h04, 1'b1, 4'd6},  // R6
    '{8'h9C, 1'b0, 32'h0,         8'h00, 32'h04, 1'b1, 4'd7},  // R7
    '{8'h94, 1'b1, 32'h0,         8'h00, 32'h04, 1'b1, 4'd5},  // R5
    '{8'h94, 1'b1, 32'h0000_0004, 8'h00, 32'h00, 1'b0, 4'd5},  // R5
    '{8'h90, 1'b0, 32'h0,         8'h00, 32'h01, 1'b0, 4'd6},  // R6
    '{8'h90, 1'b0, 32'h0,         8'h80, 32'h81, 1'b0, 4'd2},  // R2
    '{8'h94, 1'b1, 32'h0000_0080, 8'h80, 32'h00, 1'b0, 4'd5},  // R5
    '{8'h90, 1'b0, 32'h0,         8'h80, 32'h01, 1'b0, 4'd3},  // R3
    '{8'h90, 1'b0, 32'h0,         8'h00, 32'h01, 1'b0, 4'd3},  // R3
    '{8'h94, 1'b1, 32'h0000_0080, 8'h80, 32'h00, 1'b0, 4'd9},  // R9
    '{8'h90, 1'b0, 32'h0,         8'h80, 32'h81, 1'b0, 4'd9},  // R9
    '{8'h9C, 1'b1, 32'h0000_0004, 8'h80, 32'h00, 1'b0, 4'd7},  // R7
    '{8'h98, 1'b1, 32'h0000_0080, 8'h80, 32'h80, 1'b1, 4'd8},  // R8
    '{8'h94, 1'b0, 32'h0,         8'h80, 32'h80, 1'b1, 4'd6},  // R6
    '{8'hA0, 1'b1, 32'h0000_00FF, 8'h80, 32'h00, 1'b1, 4'd10}, // R10
    '{8'h90, 1'b0, 32'h0,         8'h80, 32'h81, 1'b1, 4'd10}, // R10
    '{8'h91, 1'b0, 32'h0,         8'h80, 32'h00, 1'b1, 4'd10}, // R10
    '{8'h9C, 1'b1, 32'hFFFF_FFFF, 8'h80, 32'h00, 1'b0, 4'd8}   // R8
  };

  task automatic check(input int rq, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic w,
                      input logic [31:0] d, input logic [7:0] r);
    @(negedge clk);
    bus_addr  = a;
    bus_wr    = w;
    bus_wdata = d;
    req_irq   = r;
    @(posedge clk);
    #1;
  endtask

  task automatic peek(input int rq, input logic [7:0] a,
                      input logic [31:0] exp, input logic exp_irq);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    #1;
    check(rq, "rdata", bus_rdata, exp);
    check(rq, "irq", {31'd0, irq_out}, {31'd0, exp_irq});
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_wr = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    total     = 0;
    bad       = 0;
    rst_n     = 1'b0;
    req_irq   = 8'h00;
    bus_addr  = 8'h00;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    do_reset();

    // R1: reset state on every bank word
    peek(1, 8'h90, 32'h0, 1'b0);
    peek(1, 8'h94, 32'h0, 1'b0);
    peek(1, 8'h98, 32'h0, 1'b0);
    peek(1, 8'h9C, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].addr, VECS[i].wr, VECS[i].wdata, VECS[i].req);
      check(int'(VECS[i].rq), "rdata", bus_rdata, VECS[i].exp_rd);
      check(int'(VECS[i].rq), "irq", {31'd0, irq_out}, {31'd0, VECS[i].exp_irq});
    end

    // R1 / R3: fill the mask, then reset with line 6 held high
    step(8'h98, 1'b1, 32'h0000_00FF, 8'h80);
    @(negedge clk);
    bus_wr  = 1'b0;
    req_irq = 8'h40;
    do_reset();
    peek(1, 8'h98, 32'h0, 1'b0);
    peek(3, 8'h90, 32'h0, 1'b0);
    repeat (3) @(negedge clk);
    peek(3, 8'h90, 32'h0, 1'b0);

    // R2: drop and raise line 6 again
    step(8'h90, 1'b0, 32'h0, 8'h00);
    step(8'h90, 1'b0, 32'h0, 8'h40);
    check(2, "rdata", bus_rdata, 32'h40);

    // R2: lines 0..5 rising together, line 6 held
    step(8'h90, 1'b0, 32'h0, 8'h7F);
    check(2, "rdata", bus_rdata, 32'h7F);

    // R8: enable bit 1 only, then clear its event
    step(8'h98, 1'b1, 32'h0000_0002, 8'h7F);
    check(8, "irq", {31'd0, irq_out}, 32'd1);
    step(8'h94, 1'b1, 32'h0000_0002, 8'h7F);
    check(8, "irq", {31'd0, irq_out}, 32'd0);
    peek(6, 8'h90, 32'h7D, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule